// File: doc/BRIEF.md
# Pixel Parity Guard with Last-Good Hold

This block sits on the receive side of a serial display link, in the pixel clock domain. Each received pixel arrives as 27 data bits, one parity bit and a valid strobe. The block checks the pixel against odd parity. A pixel that passes goes to a registered output. A pixel that fails is thrown away. In its place the output keeps showing the most recent pixel that passed, and a one-cycle error pulse is raised.

The transmit side sets the parity bit so that the count of ones across the data bits and the parity bit is always odd. The block does not try to repair a bad pixel. It only holds and reports. Shutdown of the link is applied through the reset input, which also clears the record of having seen a good pixel. The reset output pixel is all zeros.

Top module: `pg_guard`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_pixel` is all zeros and `out_err` is 0.
- R2: When `in_valid` is 1 and the ones across `in_pixel[26:0]` and `in_par` add up to an odd count, `in_pixel` appears on `out_pixel` one clock later and `out_err` is 0 in that cycle. The transmit rule is that `in_par` is 1 when `in_pixel` holds an even number of ones, and 0 otherwise.
- R3: When `in_valid` is 1 and the count of ones is even, the received pixel is discarded. `out_pixel` keeps the last pixel that passed R2.
- R4: When a failing pixel arrives and no pixel has passed since reset, `out_pixel` stays all zeros. A reset issued after good pixels clears that history.
- R5: `out_err` is 1 in exactly the cycle after a failing strobe, and 0 in every other cycle.
- R6: Consecutive failing pixels each give their own one-cycle pulse on `out_err`. Through all of them `out_pixel` keeps the same held pixel.
- R7: When `in_valid` is 0, `in_pixel` and `in_par` have no effect. `out_pixel` keeps its value and `out_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; also used as shutdown |
| in_valid | input | 1 | Strobe: a pixel is present this cycle |
| in_pixel | input | 27 | Received pixel data |
| in_par | input | 1 | Received parity bit |
| out_pixel | output | 27 | Registered pixel: last good pixel, or zeros |
| out_err | output | 1 | One-cycle pulse per failing pixel |

## Verification
The bench sends a failing pixel straight after reset. A design that forwards the bad data, instead of holding zeros, fails this case. It sends two failing pixels back to back. A design that stretches or merges the pulses, or that updates its hold register from bad data, fails here. It sends a pixel with a flipped data bit and an intact parity bit, which catches a checker that looks only at the parity bit. It also sends idle cycles with changing data on the inputs, which catches a design that loads while the strobe is low. Finally, it applies reset after good traffic. A design that keeps the old pixel history across reset then shows a stale pixel when the next error arrives.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int unsigned PIX_W_DEF = 27;
  localparam int unsigned GRP_DEF   = 7;
  localparam int unsigned FOLD_MAX  = 64;

  // XOR fold of a vector zero-extended to FOLD_MAX bits
  function automatic logic xor_fold(input logic [FOLD_MAX-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < FOLD_MAX; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  // number of groups needed to cover n bits with groups of g
  function automatic int unsigned n_groups(input int unsigned n, input int unsigned g);
    return (n + g - 1) / g;
  endfunction

endpackage

// File: rtl/pg_parity_chk.sv
module pg_parity_chk
  import pg_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF,
  parameter int unsigned GRP   = GRP_DEF
) (
  input  logic [PIX_W-1:0] pixel,
  input  logic             par,
  output logic             ok
);

  localparam int unsigned TOT_W = PIX_W + 1;
  localparam int unsigned NGRP  = n_groups(TOT_W, GRP);
  localparam int unsigned PAD_W = NGRP * GRP;

  logic [PAD_W-1:0] padded;
  logic [NGRP-1:0]  grp_x;

  assign padded = PAD_W'({par, pixel});

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [FOLD_MAX-1:0] slice_ext;
    assign slice_ext = FOLD_MAX'(padded[g*GRP +: GRP]);
    assign grp_x[g]  = xor_fold(slice_ext);
  end

  // odd count of ones across data and parity means the pixel is sound
  assign ok = ^grp_x;

endmodule

// File: rtl/pg_hold_reg.sv
module pg_hold_reg #(
  parameter int unsigned PIX_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] q,
  output logic             have_good
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q         <= '0;
      have_good <= 1'b0;
    end else if (load) begin
      q         <= din;
      have_good <= 1'b1;
    end
  end

endmodule

// File: rtl/pg_err_pulse.sv
module pg_err_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= fire;
  end

endmodule

// File: rtl/pg_guard.sv
module pg_guard
  import pg_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF,
  parameter int unsigned GRP   = GRP_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             in_par,
  output logic [PIX_W-1:0] out_pixel,
  output logic             out_err
);

  // named internal events, visible to the bound checker
  logic chk_ok;
  logic take_good;
  logic drop_bad;
  logic have_good;

  pg_parity_chk #(.PIX_W(PIX_W), .GRP(GRP)) u_chk (
    .pixel (in_pixel),
    .par   (in_par),
    .ok    (chk_ok)
  );

  assign take_good = in_valid & chk_ok;
  assign drop_bad  = in_valid & ~chk_ok;

  pg_hold_reg #(.PIX_W(PIX_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_good),
    .din       (in_pixel),
    .q         (out_pixel),
    .have_good (have_good)
  );

  pg_err_pulse u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (drop_bad),
    .err   (out_err)
  );

endmodule

// File: rtl/pg_guard_sva.sv
module pg_guard_sva #(
  parameter int unsigned PIX_W = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_pixel,
  input logic             chk_ok,
  input logic             have_good,
  input logic [PIX_W-1:0] out_pixel,
  input logic             out_err
);

  p_pass_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && chk_ok) |=> (out_pixel == $past(in_pixel)) && !out_err);

  p_hold_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !chk_ok) |=> $stable(out_pixel));

  p_zero_no_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !have_good |-> (out_pixel == '0));

  p_err_after_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !chk_ok) |=> out_err);

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !chk_ok) |=> !out_err);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pixel) && !out_err);

endmodule

bind pg_guard pg_guard_sva #(.PIX_W(PIX_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_pixel  (in_pixel),
  .chk_ok    (chk_ok),
  .have_good (have_good),
  .out_pixel (out_pixel),
  .out_err   (out_err)
);

// File: tb/test_pg_guard.sv
module test_pg_guard;

  localparam int W = 27;
  localparam int NV = 10;
  localparam int VW = 1 + 1 + W + W + 1 + 8;

  // {valid, corrupt, pixel sent, expected pixel, expected err, req id}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b1, 27'h1234567, 27'h0000000, 1'b1, 8'd4},
    {1'b1, 1'b0, 27'h1234567, 27'h1234567, 1'b0, 8'd2},
    {1'b1, 1'b0, 27'h7FFFFFF, 27'h7FFFFFF, 1'b0, 8'd2},
    {1'b1, 1'b1, 27'h0000001, 27'h7FFFFFF, 1'b1, 8'd3},
    {1'b1, 1'b1, 27'h5555555, 27'h7FFFFFF, 1'b1, 8'd6},
    {1'b0, 1'b0, 27'h2AAAAAA, 27'h7FFFFFF, 1'b0, 8'd7},
    {1'b1, 1'b0, 27'h0000000, 27'h0000000, 1'b0, 8'd2},
    {1'b1, 1'b0, 27'h2AAAAAA, 27'h2AAAAAA, 1'b0, 8'd2},
    {1'b1, 1'b1, 27'h2AAAAAB, 27'h2AAAAAA, 1'b1, 8'd3},
    {1'b1, 1'b0, 27'h5555555, 27'h5555555, 1'b0, 8'd5}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_pixel = '0;
  logic         in_par = 1'b0;
  logic [W-1:0] out_pixel;
  logic         out_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pg_guard i_pg_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pixel  (in_pixel),
    .in_par    (in_par),
    .out_pixel (out_pixel),
    .out_err   (out_err)
  );

  // transmit rule: parity is 1 when the data hold an even count of ones
  function automatic logic tx_par(input logic [W-1:0] p);
    int ones;
    ones = 0;
    for (int i = 0; i < W; i++) if (p[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  task automatic chk_pix(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s out_pixel act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_err(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s out_err act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic bad, input logic [W-1:0] p);
    @(negedge clk);
    in_valid = v;
    in_pixel = p;
    in_par   = tx_par(p) ^ bad;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_pix("R1", out_pixel, '0);
    chk_err("R1", out_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pix("R1", out_pixel, '0);
    chk_err("R1", out_err, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] e;
      string rq;
      e = VEC[k];
      send(e[VW-1], e[VW-2], e[VW-3 -: W]);
      rq = $sformatf("R%0d", e[7:0]);
      @(negedge clk);
      chk_pix(rq, out_pixel, e[VW-3-W -: W]);
      chk_err(rq, out_err, e[8]);
      in_valid = 1'b0;
    end

    // R5: pulse ends after one cycle; R7: idle with junk data
    send(1'b1, 1'b1, 27'h0F0F0F0);
    send(1'b0, 1'b1, 27'h3333333);
    chk_err("R5", out_err, 1'b1);
    @(negedge clk);
    chk_err("R5", out_err, 1'b0);
    chk_pix("R7", out_pixel, 27'h5555555);

    // R4: reset after good traffic clears the history
    rst_n = 1'b0;
    @(negedge clk);
    chk_pix("R4", out_pixel, '0);
    rst_n = 1'b1;
    send(1'b1, 1'b1, 27'h4444444);
    @(negedge clk);
    chk_pix("R4", out_pixel, '0);
    chk_err("R4", out_err, 1'b1);
    in_valid = 1'b0;

    // R6: three failing pixels in a row after a good one
    send(1'b1, 1'b0, 27'h0ABCDEF);
    for (int j = 0; j < 3; j++) begin
      send(1'b1, 1'b1, 27'h1111111 * (j + 1));
      if (j > 0) chk_err("R6", out_err, 1'b1);
      chk_pix("R6", out_pixel, 27'h0ABCDEF);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk_err("R6", out_err, 1'b1);
    chk_pix("R6", out_pixel, 27'h0ABCDEF);
    @(negedge clk);
    chk_err("R5", out_err, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule